// File: doc/BRIEF.md
# Framed Three-Bit Pattern Detector

This block watches a serial bit stream and cuts it into back-to-back groups of three bits that do not overlap. The first accepted bit after reset opens the first group. On the third bit of a group it raises a single-cycle detect flag when the group reads 010 or 110, with the first bit shown leftmost. Put another way, the flag rises when the middle bit is 1 and the closing bit is 0. The value of the opening bit plays no part.

A bit counts only on a cycle where the valid strobe is high. Idle cycles neither advance the framing nor raise the flag. The controller uses the reduced four-phase form: awaiting the first bit, awaiting the second bit, and two phases that await the closing bit and record whether the middle bit was 0 or 1. The flag is a Mealy output, formed combinationally from the current phase and the present input. A parameter picks either a dense two-bit state code or a four-bit one-hot state code. Both choices behave the same at the ports.

Top module: `frame_pattern_detector`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) returns the block to the frame-start phase, so the next valid bit is taken as the first bit of a new frame.
- R2: On the third valid bit of a frame, detect is 1 exactly when the second bit of that frame was 1 and the present bit_in is 0. Frames 010 and 110 flag; the other six frames do not.
- R3: detect is 0 on the first and on the second valid bit of every frame, whatever the bit values.
- R4: After the third valid bit the block returns to frame start whatever that bit was. Frames never overlap: in the stream 0,1,0,1,1,0 the flag rises on bits 3 and 6 only.
- R5: While bit_valid is 0, detect is 0 and the framing phase does not change.
- R6: detect is never high on two consecutive cycles.
- R7: While rst is high, detect is 0, even if the inputs would otherwise complete a matching frame.
- R8: With ONE_HOT=1 the state register holds exactly one set bit out of four. With ONE_HOT=0 it holds a two-bit code. Port behaviour is identical for both settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | High when bit_in carries a stream bit this cycle |
| bit_in | input | 1 | Serial data bit |
| detect | output | 1 | Single-cycle flag on the closing bit of a 010 or 110 frame |

## Verification
Three of the block's functions can fall on the same cycle. The closing bit of a frame can raise the flag while the phase wraps back to frame start, and a reset can arrive on a cycle that would otherwise complete a matching frame. The bench provokes the first case with the stream 0,1,0,1,1,0, where a match is followed at once by a new frame, and judges that the flag rises only on bits 3 and 6. It provokes the second case by asserting reset together with a valid closing 0 after a middle 1. It expects no flag on that cycle and then a clean detection from a freshly started 010 frame. A bit-counting reference model judges every cycle of both state encodings over an exhaustive sweep of all eight frames and a long random stream with idle gaps and sparse resets.

// File: rtl/fdet_pkg.sv
package fdet_pkg;

    // Symbolic framing phases of the reduced controller
    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,   // waiting for bit 1 of a frame
        PH_SECOND = 2'd1,   // bit 1 seen, waiting for bit 2
        PH_MID0   = 2'd2,   // bit 2 was 0, waiting for bit 3
        PH_MID1   = 2'd3    // bit 2 was 1, waiting for bit 3
    } phase_e;

    localparam int NUM_PHASES = 4;
    localparam int FRAME_LEN  = 3;

    // Width of the stored state code for a given encoding choice
    function automatic int code_width(input bit one_hot);
        return one_hot ? NUM_PHASES : $clog2(NUM_PHASES);
    endfunction

    // Phase reached after consuming one valid bit
    function automatic phase_e advance(input phase_e cur, input logic b);
        phase_e nxt;
        case (cur)
            PH_FIRST:  nxt = PH_SECOND;
            PH_SECOND: nxt = b ? PH_MID1 : PH_MID0;
            default:   nxt = PH_FIRST;     // closing bit: frame ends
        endcase
        return nxt;
    endfunction

    // Mealy match condition on the closing bit
    function automatic logic closes_match(input phase_e cur, input logic b);
        return (cur == PH_MID1) && !b;
    endfunction

endpackage

// File: rtl/fdet_step.sv
module fdet_step
    import fdet_pkg::*;
(
    input  phase_e cur,
    input  logic   bit_valid,
    input  logic   bit_in,
    output phase_e nxt
);

    always_comb begin
        if (bit_valid) nxt = advance(cur, bit_in);
        else           nxt = cur;
    end

endmodule

// File: rtl/fdet_store.sv
module fdet_store
    import fdet_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0,
    parameter int CW      = code_width(ONE_HOT)
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        nxt,
    output phase_e        cur,
    output logic [CW-1:0] code
);

    generate
        if (ONE_HOT) begin : g_onehot
            logic [CW-1:0] code_q;
            logic [CW-1:0] unit;
            assign unit = CW'(1);

            always_ff @(posedge clk) begin
                if (rst) code_q <= unit;
                else     code_q <= unit << nxt;
            end

            always_comb begin
                cur = PH_FIRST;
                for (int i = 0; i < NUM_PHASES; i++) begin
                    if (code_q[i]) cur = phase_e'(i[1:0]);
                end
            end

            assign code = code_q;
        end else begin : g_dense
            logic [CW-1:0] code_q;

            always_ff @(posedge clk) begin
                if (rst) code_q <= CW'(PH_FIRST);
                else     code_q <= CW'(nxt);
            end

            assign cur  = phase_e'(code_q[1:0]);
            assign code = code_q;
        end
    endgenerate

endmodule

// File: rtl/fdet_flag.sv
module fdet_flag
    import fdet_pkg::*;
(
    input  logic   rst,
    input  phase_e cur,
    input  logic   bit_valid,
    input  logic   bit_in,
    output logic   detect
);

    always_comb begin
        detect = !rst && bit_valid && closes_match(cur, bit_in);
    end

endmodule

// File: rtl/frame_pattern_detector.sv
module frame_pattern_detector
    import fdet_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic detect
);

    localparam int CW = code_width(ONE_HOT);

    phase_e        phase;
    phase_e        phase_nxt;
    logic [CW-1:0] state_code;

    fdet_step u_step (
        .cur       (phase),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .nxt       (phase_nxt)
    );

    fdet_store #(
        .ONE_HOT (ONE_HOT),
        .CW      (CW)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .nxt  (phase_nxt),
        .cur  (phase),
        .code (state_code)
    );

    fdet_flag u_flag (
        .rst       (rst),
        .cur       (phase),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .detect    (detect)
    );

endmodule

// File: rtl/fdet_checker.sv
module fdet_checker
    import fdet_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0,
    parameter int CW      = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          bit_valid,
    input logic          bit_in,
    input logic          detect,
    input phase_e        phase,
    input logic [CW-1:0] state_code
);

    // R1
    reset_start_chk: assert property (@(posedge clk)
        rst |=> (phase == PH_FIRST));

    // R3
    quiet_first_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && phase == PH_FIRST) |-> !detect);

    // R3
    quiet_second_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && phase == PH_SECOND) |-> !detect);

    // R4
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && (phase == PH_MID0 || phase == PH_MID1)) |=> (phase == PH_FIRST));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> $stable(phase));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |-> !detect);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        detect |=> !detect);

    // R7
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> !detect);

    generate
        if (ONE_HOT) begin : g_oh_chk
            // R8
            onehot_code_chk: assert property (@(posedge clk) disable iff (rst)
                $countones(state_code) == 1);
        end
    endgenerate

endmodule

bind frame_pattern_detector fdet_checker #(
    .ONE_HOT (ONE_HOT),
    .CW      (CW)
) u_fdet_checker (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .detect     (detect),
    .phase      (phase),
    .state_code (state_code)
);

// File: tb/test_frame_pattern_detector.sv
`timescale 1ns/1ps
module test_frame_pattern_detector;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vld = 1'b0;
    logic xin = 1'b0;
    logic det_d;
    logic det_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model state
    int   ref_pos  = 0;      // index of next bit within frame (0..2)
    logic ref_mid  = 1'b0;   // second bit of current frame
    logic prev_exp = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    frame_pattern_detector #(.ONE_HOT(1'b0)) i_frame_pattern_detector (
        .clk (clk), .rst (rst), .bit_valid (vld), .bit_in (xin), .detect (det_d)
    );

    frame_pattern_detector #(.ONE_HOT(1'b1)) i_frame_pattern_detector_oh (
        .clk (clk), .rst (rst), .bit_valid (vld), .bit_in (xin), .detect (det_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: detect=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle, check detect before the edge, then advance the model.
    task automatic step(input logic r, input logic v, input logic x, input string force_tag);
        logic  exp;
        string tag;
        @(negedge clk);
        rst = r; vld = v; xin = x;
        #1;
        exp = !r && v && (ref_pos == 2) && ref_mid && !x;
        if (force_tag != "")  tag = force_tag;
        else if (r)           tag = "R7";
        else if (prev_exp)    tag = "R6";
        else if (!v)          tag = "R5";
        else if (ref_pos == 2) tag = "R2";
        else                  tag = "R3";
        check({tag, " dense"}, det_d, exp);
        check({tag, "/R8 onehot"}, det_o, exp);
        prev_exp = exp;
        if (r) begin
            ref_pos = 0;
        end else if (v) begin
            if (ref_pos == 1) ref_mid = x;
            ref_pos = (ref_pos == 2) ? 0 : ref_pos + 1;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        // reset state: detect low while reset held, even with valid data
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b0, "R7");

        // exhaustive sweep of all eight frames, with idle gaps on odd frames
        for (int f = 0; f < 8; f++) begin
            for (int b = 2; b >= 0; b--) begin
                step(1'b0, 1'b1, f[b], "");
                if (f[0]) step(1'b0, 1'b0, ~f[b], "R5");
            end
        end

        // non-overlap: 0,1,0,1,1,0 flags on bits 3 and 6 only
        step(1'b0, 1'b1, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b1, "R4");
        step(1'b0, 1'b1, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b1, "R4");
        step(1'b0, 1'b1, 1'b1, "R4");
        step(1'b0, 1'b1, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b0, "R6");

        // finish the frame opened above, then reset on a would-be match
        step(1'b0, 1'b1, 1'b1, "");
        step(1'b0, 1'b1, 1'b1, "");
        step(1'b0, 1'b1, 1'b1, "");
        step(1'b0, 1'b1, 1'b1, "");
        step(1'b1, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b1, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, 1'b0, "R1");

        // long random stream with idle gaps and sparse resets
        for (int i = 0; i < 4000; i++) begin
            int   rv = $urandom;
            logic r  = (rv % 211) == 0;
            logic v  = ((rv >> 8) & 3) != 0;
            logic x  = rv[20];
            step(r, v, x, "");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule